// File: doc/BRIEF.md
# Cumulative Row Boundary Decoder

This block tells a memory controller which of four chip-select rows holds a given physical address. Software programs one 8-bit limit per row. Each limit is the row's top boundary, taken as the address bits 31:24 with the low 24 bits zero. The rows are stacked: a row begins where the rows below it end, and row 0 begins at address zero. A row that adds no span above the rows below it is empty and is never chosen.

A lookup is started by presenting a 32-bit address with a valid strobe. One clock later the block shows the result as a one-hot row select, a hit flag and the binary row number. An address above the top of the populated space gives no hit. Limits are written through a simple write port that takes a row number and a byte.

Top module: `rowdec_top`

## Requirements
- R1: After reset all four limits are 0, so every row is empty and any lookup returns hit 0, select 0 and index 0. A later reset clears limits written before it.
- R2: When wr_en is high at a clock edge, wr_data is stored as the limit of row wr_row (0 to 3). Lookups strobed at any later edge use the new value.
- R3: Row 0 is chosen when address bits 31:24 are at least 0 and below the limit of row 0.
- R4: Row N (1 to 3) is chosen when address bits 31:24 are at least its base and below its own limit. The base of a row is the largest limit among the rows with a lower number. With limits written in non-decreasing order, this is the limit of row N-1.
- R5: A row whose limit equals its base is empty and is never selected. Addresses at that value fall through to the next non-empty row.
- R6: An address whose bits 31:24 are at or above the largest programmed limit returns hit 0, select 0 and index 0.
- R7: A row whose limit is below the limit of an earlier row is treated as empty. Later rows still start at the largest earlier limit.
- R8: On a hit, select bit N (bit 0 = row 0) is the only bit set, index equals N in binary, and hit is 1. Select never has more than one bit set.
- R9: Results are registered. The outputs show the lookup of the address strobed at one clock edge from that edge until the next. After an edge where addr_vld is low, all outputs are 0.
- R10: Address bits 23:0 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one limit register |
| wr_row | input | 2 | Row whose limit is written |
| wr_data | input | 8 | New limit (address bits 31:24) |
| addr_in | input | 32 | Physical address to decode |
| addr_vld | input | 1 | Lookup strobe for addr_in |
| row_sel | output | 4 | One-hot selected row, registered |
| row_hit | output | 1 | Address falls inside a populated row |
| row_idx | output | 2 | Binary number of the selected row |

## Verification
The bench probes each row at its exact base and at its limit minus one. A decoder with an off-by-one compare would hand the boundary address to the wrong neighbour, or to no row at all. It programs equal adjacent limits and a limit below an earlier one. A design that took the previous limit alone as the base would then select the empty row or let two rows overlap. A sweep of all 256 upper-byte values against a model catches any gap or double hit. Checks for strobe-low cycles and for a repeated reset catch outputs or limits that persist when they should clear.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    parameter int ROWS   = 4;
    parameter int LIM_W  = 8;
    parameter int ADDR_W = 32;

    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    typedef logic [LIM_W-1:0] lim_t;
    typedef logic [ROWS-1:0]  sel_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic hit;
        sel_t sel;
        idx_t idx;
    } look_t;

    function automatic lim_t lim_max(input lim_t a, input lim_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic idx_t sel_to_idx(input sel_t s);
        idx_t r;
        r = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (s[i]) r = idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/rowdec_bound_regs.sv
module rowdec_bound_regs
    import rowdec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  idx_t                       wr_row,
    input  lim_t                       wr_data,
    output logic [ROWS-1:0][LIM_W-1:0] lim_q
);

    for (genvar n = 0; n < ROWS; n++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[n] <= '0;
            end else if (wr_en && (wr_row == idx_t'(n))) begin
                lim_q[n] <= wr_data;
            end
        end
    end

    AST_CLEAR_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lim_q == '0)) else $error("limits not cleared"); // R1

endmodule

// File: rtl/rowdec_match.sv
module rowdec_match
    import rowdec_pkg::*;
(
    input  logic [ROWS-1:0][LIM_W-1:0] lim_q,
    input  lim_t                       tag,
    output logic [ROWS-1:0][LIM_W-1:0] base,
    output look_t                      look
);

    sel_t hit_vec;

    assign base[0] = '0;
    for (genvar n = 1; n < ROWS; n++) begin : g_base
        assign base[n] = lim_max(base[n-1], lim_q[n-1]);
    end

    for (genvar n = 0; n < ROWS; n++) begin : g_cmp
        assign hit_vec[n] = (tag >= base[n]) && (tag < lim_q[n]);
    end

    always_comb begin
        look.sel = hit_vec;
        look.hit = |hit_vec;
        look.idx = sel_to_idx(hit_vec);
    end

endmodule

// File: rtl/rowdec_out_reg.sv
module rowdec_out_reg
    import rowdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  look_t look_d,
    output look_t look_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            look_q <= '0;
        end else if (vld) begin
            look_q <= look_d;
        end else begin
            look_q <= '0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(vld) |-> (look_q == '0)) else $error("outputs not idle"); // R9

endmodule

// File: rtl/rowdec_top.sv
module rowdec_top
    import rowdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_row,
    input  logic [LIM_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_vld,
    output logic [ROWS-1:0]   row_sel,
    output logic              row_hit,
    output logic [IDX_W-1:0]  row_idx
);

    logic [ROWS-1:0][LIM_W-1:0] lim_q;
    logic [ROWS-1:0][LIM_W-1:0] base;
    lim_t                       tag;
    lim_t                       top_lim;
    look_t                      look_d;
    look_t                      look_q;

    assign tag     = addr_in[ADDR_W-1 -: LIM_W];
    assign top_lim = lim_max(base[ROWS-1], lim_q[ROWS-1]);

    rowdec_bound_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .lim_q   (lim_q)
    );

    rowdec_match u_match (
        .lim_q (lim_q),
        .tag   (tag),
        .base  (base),
        .look  (look_d)
    );

    rowdec_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .vld    (addr_vld),
        .look_d (look_d),
        .look_q (look_q)
    );

    assign row_sel = look_q.sel;
    assign row_hit = look_q.hit;
    assign row_idx = look_q.idx;

    AST_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel)) else $error("multiple rows"); // R8

    AST_IDX_MATCHES_SEL: assert property (@(posedge clk) disable iff (rst)
        row_hit |-> (row_sel[row_idx] && $countones(row_sel) == 1)) else $error("index mismatch"); // R8

    AST_BEYOND_TOP: assert property (@(posedge clk) disable iff (rst)
        ($past(addr_vld) && ($past(tag) >= $past(top_lim))) |-> (!row_hit && row_idx == '0))
        else $error("hit above top"); // R6

    for (genvar n = 0; n < ROWS; n++) begin : g_chk
        AST_EMPTY_ROW: assert property (@(posedge clk) disable iff (rst)
            ($past(lim_q[n] <= base[n])) |-> !row_sel[n]) else $error("empty row hit"); // R5
    end

endmodule

// File: tb/rowdec_top_tb_top.sv
module rowdec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_row = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] addr_in = '0;
    logic        addr_vld = 1'b0;
    logic [3:0]  row_sel;
    logic        row_hit;
    logic [1:0]  row_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rowdec_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .addr_in(addr_in), .addr_vld(addr_vld),
        .row_sel(row_sel), .row_hit(row_hit), .row_idx(row_idx)
    );

    // {lim0, lim1, lim2, lim3, upper address byte, expected select}
    localparam int NV = 19;
    localparam logic [43:0] VEC [NV] = '{
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 4'b0001},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h0F, 4'b0001},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h10, 4'b0010},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h2F, 4'b0100},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h3F, 4'b1000},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'h40, 4'b0000},
        {8'h10, 8'h20, 8'h30, 8'h40, 8'hFF, 4'b0000},
        {8'h10, 8'h10, 8'h30, 8'h30, 8'h10, 4'b0100},
        {8'h10, 8'h10, 8'h30, 8'h30, 8'h0F, 4'b0001},
        {8'h10, 8'h10, 8'h30, 8'h30, 8'h30, 4'b0000},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'h15, 4'b0001},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'h20, 4'b0100},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'h2F, 4'b0100},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'h30, 4'b1000},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'hFE, 4'b1000},
        {8'h20, 8'h10, 8'h30, 8'hFF, 8'hFF, 4'b0000},
        {8'h00, 8'h00, 8'h00, 8'h80, 8'h7F, 4'b1000},
        {8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 4'b1000},
        {8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 4'b0000}
    };

    task automatic wr_lim(input int r, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(r); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_out(input string req, input logic [3:0] exp_sel);
        logic       exp_hit;
        logic [1:0] exp_idx;
        exp_hit = |exp_sel;
        exp_idx = 2'd0;
        for (int i = 0; i < 4; i++) if (exp_sel[i]) exp_idx = 2'(i);
        n_chk++;
        if (row_sel !== exp_sel || row_hit !== exp_hit || row_idx !== exp_idx) begin
            n_fail++;
            $display("FAIL %s: sel=%b hit=%b idx=%0d expected sel=%b hit=%b idx=%0d",
                     req, row_sel, row_hit, row_idx, exp_sel, exp_hit, exp_idx);
        end
    endtask

    task automatic lookup(input logic [31:0] a, input string req, input logic [3:0] exp_sel);
        @(negedge clk);
        addr_in = a; addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
        check_out(req, exp_sel);
    endtask

    function automatic logic [3:0] model(input logic [7:0] l0, l1, l2, l3, input logic [7:0] t);
        logic [7:0] lims [4];
        logic [7:0] b;
        logic [3:0] s;
        lims[0] = l0; lims[1] = l1; lims[2] = l2; lims[3] = l3;
        b = 8'h00; s = 4'b0000;
        for (int i = 0; i < 4; i++) begin
            if (t >= b && t < lims[i]) s[i] = 1'b1;
            if (lims[i] > b) b = lims[i];
        end
        return s;
    endfunction

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_out("R1 reset outputs", 4'b0000);
        lookup(32'h0000_0000, "R1 empty after reset", 4'b0000);
        lookup(32'hFFFF_FFFF, "R1 empty after reset", 4'b0000);

        // table walk: R2..R8 and R10 through varied low address bits
        for (int v = 0; v < NV; v++) begin
            logic [43:0] e;
            e = VEC[v];
            wr_lim(0, e[43:36]);
            wr_lim(1, e[35:28]);
            wr_lim(2, e[27:20]);
            wr_lim(3, e[19:12]);
            lookup({e[11:4], (v % 2 == 1) ? 24'hFFFFFF : 24'h000000},
                   "R3 R4 R5 R6 R7 R8 R10 table", e[3:0]);
        end

        // R10: low bits do not matter
        wr_lim(0, 8'h10); wr_lim(1, 8'h20); wr_lim(2, 8'h30); wr_lim(3, 8'h40);
        lookup(32'h1F5A_C3E1, "R10 low bits", 4'b0010);
        lookup(32'h1F00_0000, "R10 low bits", 4'b0010);

        // R9: strobe low gives zero outputs after a hit
        lookup(32'h2000_0000, "R9 hit before idle", 4'b0100);
        @(negedge clk);
        check_out("R9 idle cycle clears", 4'b0000);

        // R9: back-to-back lookups each seen one cycle later
        @(negedge clk);
        addr_in = 32'h0500_0000; addr_vld = 1'b1;
        @(negedge clk);
        check_out("R9 first of pair", 4'b0001);
        addr_in = 32'h3500_0000;
        @(negedge clk);
        addr_vld = 1'b0;
        check_out("R9 second of pair", 4'b1000);

        // R2: rewrite one limit and observe at once
        wr_lim(3, 8'h38);
        lookup(32'h3800_0000, "R2 limit rewrite", 4'b0000);
        lookup(32'h3700_0000, "R2 limit rewrite", 4'b1000);

        // full sweep against the model: R4 R5 R7
        wr_lim(0, 8'h05); wr_lim(1, 8'h40); wr_lim(2, 8'h40); wr_lim(3, 8'hC0);
        for (int t = 0; t < 256; t++)
            lookup({8'(t), 24'h123456}, "R4 R5 sweep", model(8'h05, 8'h40, 8'h40, 8'hC0, 8'(t)));
        wr_lim(0, 8'h90); wr_lim(1, 8'h20); wr_lim(2, 8'hA0); wr_lim(3, 8'h50);
        for (int t = 0; t < 256; t++)
            lookup({8'(t), 24'h0}, "R7 sweep", model(8'h90, 8'h20, 8'hA0, 8'h50, 8'(t)));

        // R1: second reset clears the limits
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lookup(32'h1000_0000, "R1 reset clears limits", 4'b0000);
        lookup(32'h9500_0000, "R1 reset clears limits", 4'b0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule